// File: doc/BRIEF.md
# Fuse PROM Programming Sequencer

This controller takes a fuse-link PROM word through a timed blow-and-check cycle. A host puts a word address, a mask of the output bits to blow and a strike width in microseconds on the inputs, then pulses `start`. The sequencer presents the address and requests the programming supply. It then visits the selected bits from the least significant to the most significant, one at a time. For each bit it raises that output's programming pulse, strobes the chip-enable line low for the strike width, and releases the pulse. Each step is separated by a fixed settle interval. A blown fuse reads back as 1. After the last bit the word is read twice, first at the high verify supply and then at the low verify supply. Any selected bit that reads 0 in either read marks the word as a reject.

All delays are counted in clock cycles. The settle interval is `SETTLE_US` microseconds, and a strike lasts `pulse_us` microseconds. Both are converted with `CLK_HZ`, which must be a whole number of megahertz. The analog drivers act on the supply code, the pulse vector and the chip-enable output. Building those drivers is the integrator's job.

States and transitions: `ST_IDLE` goes to `ST_RAISE` on `start`. `ST_RAISE` (supply at program level, settle) goes to `ST_ARM` if any bit is pending, else to `ST_VFY_HI`. `ST_ARM` (pulse on, settle) goes to `ST_STRIKE` (chip enable low for the strike width). `ST_STRIKE` goes to `ST_HOLD` (pulse still on, settle). `ST_HOLD` goes to `ST_GAP` (pulse off, settle). `ST_GAP` goes to `ST_ARM` for the next pending bit, else to `ST_VFY_HI`. `ST_VFY_HI` goes to `ST_VFY_LO`. `ST_VFY_LO` goes to `ST_DONE` (one cycle). `ST_DONE` goes to `ST_IDLE`.

Top module: `fuse_prog_seq`

## Requirements
- R1: During and after reset, `busy`, `done`, `pass` and `prog_pulse` are 0, `supply_req` is 0 (nominal) and `ce_n` is 1.
- R2: In the cycle after `start` is taken in idle, `busy` rises, `addr_out` shows the captured address and stays there for the whole run, `supply_req` becomes 1 (program) with `ce_n` high, and no bit is pulsed for the first S cycles (S = SETTLE_US·CLK_HZ/10^6).
- R3: At most one bit of `prog_pulse` is high at any time. Exactly the mask bits are pulsed, each once, in ascending bit order.
- R4: Each bit's window holds the pulse for S cycles with `ce_n` high, then for T cycles with `ce_n` low, then for S more cycles with `ce_n` high. The pulse then drops.
- R5: `supply_req` stays 1 (program) from the end of R2 through all bit windows. S cycles with no pulse and `ce_n` high follow every bit window, including the last one.
- R6: T equals `pulse_us`·CLK_HZ/10^6 cycles, with a `pulse_us` of 0 treated as 1.
- R7: Verify takes S cycles with `supply_req` 2 (verify-high) and `ce_n` low, then S cycles with `supply_req` 3 (verify-low) and `ce_n` low. `dev_data` is sampled in the last cycle of each. With an empty mask, verify follows the R2 settle directly.
- R8: `pass` is 1 with `done` only if every mask bit of `dev_data` read 1 in both samples. Bits outside the mask have no effect, and an empty mask passes.
- R9: `done` is high for exactly one cycle, the last cycle of `busy`, with supply nominal and `ce_n` high. `pass` is 0 whenever `done` is 0. In the next cycle `busy` is 0.
- R10: `start` is ignored while `busy` is 1, including the `done` cycle. Changes to `addr_in`, `mask_in` and `pulse_us` after the start cycle do not alter the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | begin a run (taken only in idle) |
| addr_in | input | AW | word address to program |
| mask_in | input | DW | outputs to blow, 1 = blow |
| pulse_us | input | PW | strike width in microseconds |
| dev_data | input | DW | device outputs read during verify |
| busy | output | 1 | run in progress |
| done | output | 1 | one-cycle end-of-run strobe |
| pass | output | 1 | word verified, valid with done |
| supply_req | output | 2 | 0 nominal, 1 program, 2 verify-high, 3 verify-low |
| ce_n | output | 1 | chip enable, active low |
| prog_pulse | output | DW | per-output programming pulse |
| addr_out | output | AW | address bus to the device |

## Verification
Two events can land in the same cycle. The first is the one-cycle `done` strobe, which is the last cycle of a run. The second is a new `start` request, which the block must refuse because it is still busy. The bench raises `start` exactly in the observed `done` cycle. It then checks that one cycle later the block is idle, at nominal supply, with chip enable high, and that no new run has begun. Separately, a `start` with a different address is injected in the middle of a run. The full cycle-by-cycle timeline of that run is then compared against the schedule the bench computes from the captured inputs.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [1:0] {
        SUP_NOM  = 2'd0,
        SUP_PROG = 2'd1,
        SUP_VHI  = 2'd2,
        SUP_VLO  = 2'd3
    } supply_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RAISE,
        ST_ARM,
        ST_STRIKE,
        ST_HOLD,
        ST_GAP,
        ST_VFY_HI,
        ST_VFY_LO,
        ST_DONE
    } state_e;

endpackage

// File: rtl/fps_timer.sv
module fps_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          last
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - TW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign last = (cnt_q == '0);

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R6

endmodule

// File: rtl/fps_bit_pick.sv
module fps_bit_pick #(
    parameter int DW = 8,
    parameter int IW = 3
) (
    input  logic [DW-1:0] todo,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (todo[i]) idx = IW'(i);
        end
    end

    assign any = |todo;

endmodule

// File: rtl/fps_verify.sv
module fps_verify #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          sample,
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] mask,
    output logic          fail
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail <= 1'b0;
        end else if (clear) begin
            fail <= 1'b0;
        end else if (sample && ((data & mask) != mask)) begin
            fail <= 1'b1;
        end
    end

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clear) |=> fail); // R8

endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq #(
    parameter int CLK_HZ    = 100_000_000,
    parameter int SETTLE_US = 10,
    parameter int AW        = 10,
    parameter int DW        = 8,
    parameter int PW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] mask_in,
    input  logic [PW-1:0] pulse_us,
    input  logic [DW-1:0] dev_data,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic [1:0]    supply_req,
    output logic          ce_n,
    output logic [DW-1:0] prog_pulse,
    output logic [AW-1:0] addr_out
);
    import fps_pkg::*;

    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
    localparam int MAX_PULSE  = ((1 << PW) - 1) * CYC_PER_US;
    localparam int MAX_DLY    = (MAX_PULSE > SETTLE_CYC) ? MAX_PULSE : SETTLE_CYC;
    localparam int TW         = $clog2(MAX_DLY + 1);
    localparam int IW         = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [TW-1:0] SETTLE_T = TW'(SETTLE_CYC);

    state_e        state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] todo_q;
    logic [TW-1:0] strike_q;
    logic [IW-1:0] cur_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_last;
    logic          take_bit;
    logic          pick_any;
    logic [IW-1:0] pick_idx;
    logic          vfy_sample;
    logic          vfy_clear;
    logic          vfy_fail;
    supply_e       supply_d;

    fps_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    fps_bit_pick #(.DW(DW), .IW(IW)) u_pick (
        .todo (todo_q),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    fps_verify #(.DW(DW)) u_verify (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (vfy_clear),
        .sample (vfy_sample),
        .data   (dev_data),
        .mask   (mask_q),
        .fail   (vfy_fail)
    );

    // next state and delay loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = SETTLE_T;
        take_bit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_RAISE;
                    tmr_load = 1'b1;
                end
            end
            ST_RAISE, ST_GAP: begin
                if (tmr_last) begin
                    tmr_load = 1'b1;
                    if (pick_any) begin
                        state_d  = ST_ARM;
                        take_bit = 1'b1;
                    end else begin
                        state_d = ST_VFY_HI;
                    end
                end
            end
            ST_ARM: begin
                if (tmr_last) begin
                    state_d  = ST_STRIKE;
                    tmr_load = 1'b1;
                    tmr_val  = strike_q;
                end
            end
            ST_STRIKE: begin
                if (tmr_last) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                end
            end
            ST_HOLD: begin
                if (tmr_last) begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                end
            end
            ST_VFY_HI: begin
                if (tmr_last) begin
                    state_d  = ST_VFY_LO;
                    tmr_load = 1'b1;
                end
            end
            ST_VFY_LO: begin
                if (tmr_last) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign vfy_clear  = (state_q == ST_IDLE) && start;
    assign vfy_sample = tmr_last && ((state_q == ST_VFY_HI) || (state_q == ST_VFY_LO));

    // state register and run context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            mask_q   <= '0;
            todo_q   <= '0;
            strike_q <= TW'(1);
            cur_q    <= '0;
        end else begin
            state_q <= state_d;
            if (vfy_clear) begin
                addr_q   <= addr_in;
                mask_q   <= mask_in;
                todo_q   <= mask_in;
                strike_q <= TW'((pulse_us == '0) ? PW'(1) : pulse_us) * TW'(CYC_PER_US);
            end else if (take_bit) begin
                cur_q  <= pick_idx;
                todo_q <= todo_q & ~(DW'(1) << pick_idx);
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        supply_d   = SUP_NOM;
        ce_n       = 1'b1;
        prog_pulse = '0;
        busy       = 1'b1;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_RAISE:  supply_d = SUP_PROG;
            ST_ARM: begin
                supply_d   = SUP_PROG;
                prog_pulse = DW'(1) << cur_q;
            end
            ST_STRIKE: begin
                supply_d   = SUP_PROG;
                prog_pulse = DW'(1) << cur_q;
                ce_n       = 1'b0;
            end
            ST_HOLD: begin
                supply_d   = SUP_PROG;
                prog_pulse = DW'(1) << cur_q;
            end
            ST_GAP:    supply_d = SUP_PROG;
            ST_VFY_HI: begin
                supply_d = SUP_VHI;
                ce_n     = 1'b0;
            end
            ST_VFY_LO: begin
                supply_d = SUP_VLO;
                ce_n     = 1'b0;
            end
            ST_DONE:   done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign supply_req = supply_d;
    assign pass       = done && !vfy_fail;
    assign addr_out   = addr_q;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prog_pulse)); // R3
    AST_STRIKE_UNDER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_req == SUP_PROG && !ce_n) |-> (prog_pulse != '0)); // R4
    AST_PULSE_AT_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_pulse != '0) |-> (supply_req == SUP_PROG)); // R5
    AST_VERIFY_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_req == SUP_VHI || supply_req == SUP_VLO) |-> !ce_n); // R7
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && supply_req == SUP_NOM && ce_n)); // R9
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_out)); // R10
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy); // R10

endmodule

// File: tb/tb_fuse_prog_seq.sv
module tb_fuse_prog_seq;

    localparam int AW = 10;
    localparam int DW = 8;
    localparam int PW = 8;
    localparam int S  = 10;   // settle cycles at 1 MHz declared rate, 10 us

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] mask_in = '0;
    logic [PW-1:0] pulse_us = '0;
    logic [DW-1:0] dev_data;
    logic          busy, done, pass, ce_n;
    logic [1:0]    supply_req;
    logic [DW-1:0] prog_pulse;
    logic [AW-1:0] addr_out;

    logic [DW-1:0] blown = '0;
    logic [DW-1:0] weak_hi = '0;
    logic [DW-1:0] weak_lo = '0;
    logic [DW-1:0] junk = '0;
    logic [DW-1:0] cur_mask = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #5ns clk = ~clk;

    // device model: blown fuses read 1; weak bits drop out at one verify level
    assign dev_data = (supply_req == 2'd2) ? ((blown & ~weak_hi) | (junk & ~cur_mask)) :
                      (supply_req == 2'd3) ? ((blown & ~weak_lo) | (junk & ~cur_mask)) :
                      blown;

    fuse_prog_seq #(.CLK_HZ(1_000_000), .SETTLE_US(10), .AW(AW), .DW(DW), .PW(PW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in), .mask_in(mask_in),
        .pulse_us(pulse_us), .dev_data(dev_data), .busy(busy), .done(done), .pass(pass),
        .supply_req(supply_req), .ce_n(ce_n), .prog_pulse(prog_pulse), .addr_out(addr_out)
    );

    task automatic check(input bit ok, input string req, input string detail);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s", req, detail);
        end
    endtask

    // expected port values in cycle k after the start edge
    function automatic void exp_at(input int k, input logic [DW-1:0] m, input int tp,
                                   output logic [1:0] sup, output logic ce,
                                   output logic [DW-1:0] pl, output logic dn);
        int t;
        sup = 2'd1; ce = 1'b1; pl = '0; dn = 1'b0;
        if (k < S) return;
        t = k - S;
        for (int j = 0; j < DW; j++) begin
            if (m[j]) begin
                if (t < 3 * S + tp) begin
                    if (t < 2 * S + tp) pl = DW'(1) << j;
                    if (t >= S && t < S + tp) ce = 1'b0;
                    return;
                end
                t -= 3 * S + tp;
            end
        end
        if (t < S) begin sup = 2'd2; ce = 1'b0; end
        else if (t < 2 * S) begin sup = 2'd3; ce = 1'b0; end
        else begin sup = 2'd0; dn = 1'b1; end
    endfunction

    task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] m,
                          input logic [PW-1:0] pus, input logic [DW-1:0] fh,
                          input logic [DW-1:0] fl, input bit poke, input bit done_start);
        int tp, len;
        logic [1:0] e_sup; logic e_ce; logic [DW-1:0] e_pl; logic e_dn;
        string bad_pl, bad_ce, bad_sup, bad_dn, bad_ad;
        bit exp_pass;
        bad_pl = ""; bad_ce = ""; bad_sup = ""; bad_dn = ""; bad_ad = "";
        tp  = (pus == 0) ? 1 : int'(pus);
        len = S + $countones(m) * (3 * S + tp) + 2 * S + 1;
        exp_pass = ((m & (fh | fl)) == '0);
        blown = '0; weak_hi = fh; weak_lo = fl; junk = DW'($urandom); cur_mask = m;
        @(negedge clk);
        addr_in = a; mask_in = m; pulse_us = pus; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R10: inputs scrambled after capture
        addr_in = AW'($urandom); mask_in = DW'($urandom); pulse_us = PW'($urandom);
        for (int k = 0; k < len; k++) begin
            if (k > 0) @(negedge clk);
            exp_at(k, m, tp, e_sup, e_ce, e_pl, e_dn);
            if (prog_pulse !== e_pl && bad_pl == "")
                bad_pl = $sformatf("k=%0d pulse act=%b exp=%b", k, prog_pulse, e_pl);
            if (ce_n !== e_ce && bad_ce == "")
                bad_ce = $sformatf("k=%0d ce_n act=%b exp=%b", k, ce_n, e_ce);
            if (supply_req !== e_sup && bad_sup == "")
                bad_sup = $sformatf("k=%0d supply act=%0d exp=%0d", k, supply_req, e_sup);
            if ((done !== e_dn || busy !== 1'b1 || (!e_dn && pass !== 1'b0)) && bad_dn == "")
                bad_dn = $sformatf("k=%0d done/busy/pass act=%b%b%b exp=%b1x", k, done, busy, pass, e_dn);
            if (addr_out !== a && bad_ad == "")
                bad_ad = $sformatf("k=%0d addr act=%h exp=%h", k, addr_out, a);
            if (supply_req == 2'd1 && !ce_n) blown = blown | prog_pulse;
            if (e_dn) check(pass === exp_pass, "R8",
                            $sformatf("pass act=%b exp=%b mask=%b", pass, exp_pass, m));
            if (poke && k == 3) begin start = 1'b1; addr_in = ~a; end
            if (poke && k == 4) start = 1'b0;
            if (done_start && e_dn) start = 1'b1;
        end
        check(bad_ad == "", "R2", bad_ad);
        check(bad_pl == "", "R3 R4", bad_pl);
        check(bad_ce == "", "R4 R6", bad_ce);
        check(bad_sup == "", "R5 R7", bad_sup);
        check(bad_dn == "", "R9 R10", bad_dn);
        @(negedge clk);
        start = 1'b0;
        // R9, R10: idle again one cycle after done, even if start came with done
        check(busy === 1'b0 && done === 1'b0 && supply_req === 2'd0 && ce_n === 1'b1, "R9 R10",
              $sformatf("post busy=%b done=%b sup=%0d ce_n=%b exp 0 0 0 1", busy, done, supply_req, ce_n));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 0 && done === 0 && pass === 0 && supply_req === 2'd0 && ce_n === 1 &&
              prog_pulse === '0, "R1",
              $sformatf("busy=%b done=%b pass=%b sup=%0d ce_n=%b pulse=%b exp 0 0 0 0 1 0",
                        busy, done, pass, supply_req, ce_n, prog_pulse));
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        run_op(10'h155, 8'h00, 8'd3, 8'h00, 8'h00, 0, 0); // R7 R8 empty mask
        run_op(10'h3FF, 8'hFF, 8'd2, 8'h00, 8'h00, 0, 0); // R3 all bits
        run_op(10'h001, 8'h24, 8'd0, 8'h00, 8'h00, 0, 0); // R6 zero width
        run_op(10'h2A0, 8'h80, 8'd20, 8'h00, 8'h00, 0, 0); // R4 single MSB
        run_op(10'h0F0, 8'h0B, 8'd4, 8'h02, 8'h00, 0, 0); // R8 fails high verify
        run_op(10'h10F, 8'h0B, 8'd4, 8'h00, 8'h08, 0, 0); // R8 fails low verify
        run_op(10'h111, 8'h30, 8'd5, 8'hC3, 8'h0C, 0, 0); // R8 weak outside mask
        run_op(10'h222, 8'h81, 8'd1, 8'h00, 8'h00, 1, 0); // R10 start mid-run
        run_op(10'h333, 8'h06, 8'd2, 8'h00, 8'h00, 0, 1); // R10 start with done
        for (int i = 0; i < 12; i++) begin
            logic [DW-1:0] m, fh, fl;
            m  = DW'($urandom);
            fh = (($urandom % 4) == 0) ? DW'($urandom) : '0;
            fl = (($urandom % 4) == 0) ? DW'($urandom) : '0;
            run_op(AW'($urandom), m, PW'($urandom % 21), fh, fl, ($urandom % 3) == 0,
                   ($urandom % 3) == 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1500us;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired, run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule